// File: doc/BRIEF.md
# Gate Pre-Driver Channel Controller

This block is the digital controller for four low-side gate pre-driver channels. Each channel runs either as an ignition driver or as a general-purpose MOSFET driver. In ignition mode only the parallel input switches the gate. In general-purpose mode the gate command is the OR of the parallel input and a stored command bit. The analog gate drive, the clamps, the current sense and the drain monitors are outside the block. They report to the controller as digital comparator flags, and the controller returns registered gate enables, latched fault flags and a drain-threshold code.

A max-current flag on an active channel latches that channel's gate off. The latch clears once the channel's command drops. In general-purpose mode, a drain-high (short) flag seen while the gate is on must persist for a programmable filter window before it latches a short fault and turns the gate off. The window is the base time doubled once for each code step, and codes above 5 saturate at 32 base times. An open-load flag seen while the channel is commanded off is filtered by a fixed window before it latches. The active-low spark indicator is driven low while any of the four feedback comparators is active. An active-low enable forces every gate off.

Top module: `gate_predrv_ctrl`

## Requirements
- R1: After reset, every gate output and fault flag is 0, `spark_n` is 1, `thr_code` is 0, all channels are in ignition mode, and the stored commands are 0.
- R2: A channel whose mode bit is 0 (ignition) drives its gate from its parallel input alone, one clock after the input. Its stored command bit has no effect.
- R3: A channel whose mode bit is 1 (general-purpose) drives its gate from the OR of its parallel input and its stored command bit, one clock later. A `cfg_wr` pulse loads the mode, command, filter code and threshold code on that clock edge.
- R4: While `drv_en_n` is 1, every gate output is 0 from the next clock. Once `drv_en_n` returns to 0, the gates resume their commands.
- R5: If `maxi_in[i]` is 1 while channel i is commanded on, the gate turns off at the next clock. It stays off while the command stays on, even after the flag drops.
- R6: The max-current latch clears in any cycle where the channel command is 0. A max-current flag that arrives in the same cycle as a low command leaves no latch.
- R7: In general-purpose mode, with the gate on, `short_in[i]` held for BASE_CYC << code consecutive clocks sets `fault_short[i]` and clears the gate on that clock, and not before. A single clock with the flag low restarts the count.
- R8: Filter codes 6 and 7 behave as code 5, which is 32 × BASE_CYC clocks.
- R9: `fault_short[i]` and the gate turn-off persist after the short flag drops. They clear once the channel command goes to 0, and the gate follows the command again afterwards.
- R10: A channel in ignition mode never sets `fault_short`, however long the short flag is held.
- R11: With channel i commanded off, `open_in[i]` held for OPEN_CYC consecutive clocks sets `fault_open[i]`. The flag persists after `open_in` drops and clears once the channel is commanded on.
- R12: `spark_n` is 0 one clock after any bit of `spark_fb` is 1, and 1 one clock after all bits are 0.
- R13: `thr_code` presents the 3-bit drain-threshold code loaded by `cfg_wr`, from the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en_n | input | 1 | Active-low enable for all gates |
| gate_in | input | N | Parallel gate commands |
| cfg_wr | input | 1 | Loads the configuration fields |
| cfg_mode | input | N | Mode per channel: 1 general-purpose, 0 ignition |
| cfg_cmd | input | N | Stored gate command per channel |
| cfg_filt | input | 3 | Short-filter code (window = BASE_CYC << code, saturating at 5) |
| cfg_thr | input | 3 | Drain-threshold code for the analog monitor |
| maxi_in | input | N | Max-current comparator flags |
| short_in | input | N | Drain-high comparator flags (gate on) |
| open_in | input | N | Open-load comparator flags (gate off) |
| spark_fb | input | N | Feedback comparator flags |
| gate_out | output | N | Gate enables to the analog drivers |
| fault_short | output | N | Latched short faults |
| fault_open | output | N | Latched open-load faults |
| spark_n | output | 1 | Active-low spark indicator |
| thr_code | output | 3 | Stored drain-threshold code |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is the max-current latch and the command release. The bench raises `maxi_in` in the very cycle it drops the command. It then raises the command again and expects the gate back on one clock later, which proves that the release won and no latch was left behind.

The second pair is the short filter and the filter restart. The bench drops the short flag for one clock mid-window. It then expects the fault to appear only a full window after the flag returns, so the expected values for each check are computed from the requirements and compared in the exact cycle the fault should appear.

// File: rtl/gpd_pkg.sv
package gpd_pkg;

    typedef enum logic {
        MODE_IGN = 1'b0,
        MODE_GP  = 1'b1
    } ch_mode_e;

    localparam int unsigned FILT_CODE_MAX = 5;

    function automatic logic [2:0] filt_code_sat(input logic [2:0] code);
        return (code > 3'(FILT_CODE_MAX)) ? 3'(FILT_CODE_MAX) : code;
    endfunction

endpackage

// File: rtl/gpd_cfg.sv
module gpd_cfg #(
    parameter int N        = 4,
    parameter int CW       = 18,
    parameter int BASE_CYC = 6000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [N-1:0]  mode_in,
    input  logic [N-1:0]  cmd_in,
    input  logic [2:0]    filt_in,
    input  logic [2:0]    thr_in,
    output logic [N-1:0]  mode,
    output logic [N-1:0]  rcmd,
    output logic [CW-1:0] lim,
    output logic [2:0]    thr
);
    import gpd_pkg::*;

    typedef struct packed {
        logic [N-1:0] mode;
        logic [N-1:0] cmd;
        logic [2:0]   filt;
        logic [2:0]   thr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            cfg_d.mode = mode_in;
            cfg_d.cmd  = cmd_in;
            cfg_d.filt = filt_code_sat(filt_in);
            cfg_d.thr  = thr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign mode = cfg_q.mode;
    assign rcmd = cfg_q.cmd;
    assign thr  = cfg_q.thr;
    assign lim  = CW'(BASE_CYC) << cfg_q.filt;

endmodule

// File: rtl/gpd_chan.sv
module gpd_chan #(
    parameter int CW       = 18,
    parameter int OPEN_CYC = 40000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n_i,
    input  logic          mode_i,
    input  logic          par_i,
    input  logic          reg_i,
    input  logic          maxi_i,
    input  logic          short_i,
    input  logic          open_i,
    input  logic [CW-1:0] lim_i,
    output logic          gate_o,
    output logic          short_flt_o,
    output logic          open_flt_o
);
    import gpd_pkg::*;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          cmd;
        logic          mx;
        logic          sh;
        logic          op;
        logic          gate;
    } chan_t;

    chan_t ch_d, ch_q;

    logic          gp;
    logic          cmd_now;
    logic          short_cond;
    logic          open_cond;
    logic [CW-1:0] base;
    logic [CW-1:0] nxt;

    always_comb begin
        gp         = (ch_mode_e'(mode_i) == MODE_GP);
        cmd_now    = gp ? (par_i | reg_i) : par_i;
        short_cond = cmd_now & gp & ch_q.gate & short_i;
        open_cond  = ~cmd_now & open_i & ~ch_q.op;
        // one counter serves both filters; a command change restarts it
        base       = (cmd_now == ch_q.cmd) ? ch_q.cnt : '0;
        nxt        = base + CW'(1);

        ch_d     = ch_q;
        ch_d.cmd = cmd_now;
        ch_d.cnt = '0;
        ch_d.mx  = cmd_now & (ch_q.mx | maxi_i);
        ch_d.sh  = cmd_now & ch_q.sh;
        ch_d.op  = ~cmd_now & ch_q.op;

        if (short_cond) begin
            if (nxt >= lim_i) ch_d.sh  = 1'b1;
            else              ch_d.cnt = nxt;
        end else if (open_cond) begin
            if (nxt >= CW'(OPEN_CYC)) ch_d.op  = 1'b1;
            else                      ch_d.cnt = nxt;
        end

        ch_d.gate = ~en_n_i & cmd_now & ~ch_d.mx & ~ch_d.sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign gate_o      = ch_q.gate;
    assign short_flt_o = ch_q.sh;
    assign open_flt_o  = ch_q.op;

endmodule

// File: rtl/gpd_spark.sv
module gpd_spark #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fb_i,
    output logic         spark_n_o
);
    logic spk_d, spk_q;

    always_comb begin
        spk_d = ~(|fb_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) spk_q <= 1'b1;
        else        spk_q <= spk_d;
    end

    assign spark_n_o = spk_q;

endmodule

// File: rtl/gate_predrv_ctrl.sv
module gate_predrv_ctrl #(
    parameter int N        = 4,
    parameter int BASE_CYC = 6000,
    parameter int OPEN_CYC = 40000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         drv_en_n,
    input  logic [N-1:0] gate_in,
    input  logic         cfg_wr,
    input  logic [N-1:0] cfg_mode,
    input  logic [N-1:0] cfg_cmd,
    input  logic [2:0]   cfg_filt,
    input  logic [2:0]   cfg_thr,
    input  logic [N-1:0] maxi_in,
    input  logic [N-1:0] short_in,
    input  logic [N-1:0] open_in,
    input  logic [N-1:0] spark_fb,
    output logic [N-1:0] gate_out,
    output logic [N-1:0] fault_short,
    output logic [N-1:0] fault_open,
    output logic         spark_n,
    output logic [2:0]   thr_code
);
    localparam int SHORT_MAX = BASE_CYC * 32;
    localparam int LIM_MAX   = (SHORT_MAX > OPEN_CYC) ? SHORT_MAX : OPEN_CYC;
    localparam int CW        = $clog2(LIM_MAX + 1);

    logic [N-1:0]  mode;
    logic [N-1:0]  rcmd;
    logic [CW-1:0] lim;

    gpd_cfg #(.N(N), .CW(CW), .BASE_CYC(BASE_CYC)) i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .mode_in (cfg_mode),
        .cmd_in  (cfg_cmd),
        .filt_in (cfg_filt),
        .thr_in  (cfg_thr),
        .mode    (mode),
        .rcmd    (rcmd),
        .lim     (lim),
        .thr     (thr_code)
    );

    for (genvar g = 0; g < N; g++) begin : g_ch
        gpd_chan #(.CW(CW), .OPEN_CYC(OPEN_CYC)) i_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .en_n_i      (drv_en_n),
            .mode_i      (mode[g]),
            .par_i       (gate_in[g]),
            .reg_i       (rcmd[g]),
            .maxi_i      (maxi_in[g]),
            .short_i     (short_in[g]),
            .open_i      (open_in[g]),
            .lim_i       (lim),
            .gate_o      (gate_out[g]),
            .short_flt_o (fault_short[g]),
            .open_flt_o  (fault_open[g])
        );
    end

    gpd_spark #(.N(N)) i_spark (
        .clk       (clk),
        .rst_n     (rst_n),
        .fb_i      (spark_fb),
        .spark_n_o (spark_n)
    );

endmodule

// File: rtl/gate_predrv_ctrl_chk.sv
module gate_predrv_ctrl_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         drv_en_n,
    input logic [N-1:0] maxi_in,
    input logic [N-1:0] spark_fb,
    input logic [N-1:0] gate_out,
    input logic [N-1:0] fault_short,
    input logic [N-1:0] fault_open,
    input logic         spark_n
);
    AST_DISABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_n |=> (gate_out == '0));                                   // R4

    AST_SPARK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (|spark_fb) |=> !spark_n);                                        // R12

    AST_SPARK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(|spark_fb) |=> spark_n);                                        // R12

    for (genvar g = 0; g < N; g++) begin : g_chk
        AST_MAXI_CUTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            maxi_in[g] |=> !gate_out[g]);                                 // R5

        AST_SHORT_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            fault_short[g] |-> !gate_out[g]);                             // R9

        AST_OPEN_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            fault_open[g] |-> !gate_out[g]);                              // R11
    end
endmodule

bind gate_predrv_ctrl gate_predrv_ctrl_chk #(.N(N)) i_gate_predrv_ctrl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .drv_en_n    (drv_en_n),
    .maxi_in     (maxi_in),
    .spark_fb    (spark_fb),
    .gate_out    (gate_out),
    .fault_short (fault_short),
    .fault_open  (fault_open),
    .spark_n     (spark_n)
);

// File: tb/test_gate_predrv_ctrl.sv
`timescale 1ns/1ps
module test_gate_predrv_ctrl;
    localparam int N    = 4;
    localparam int BASE = 4;
    localparam int OPEN = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         drv_en_n = 1'b0;
    logic [N-1:0] gate_in = '0;
    logic         cfg_wr = 1'b0;
    logic [N-1:0] cfg_mode = '0;
    logic [N-1:0] cfg_cmd = '0;
    logic [2:0]   cfg_filt = '0;
    logic [2:0]   cfg_thr = '0;
    logic [N-1:0] maxi_in = '0;
    logic [N-1:0] short_in = '0;
    logic [N-1:0] open_in = '0;
    logic [N-1:0] spark_fb = '0;
    logic [N-1:0] gate_out;
    logic [N-1:0] fault_short;
    logic [N-1:0] fault_open;
    logic         spark_n;
    logic [2:0]   thr_code;

    always #2.5 clk = ~clk;

    gate_predrv_ctrl #(.N(N), .BASE_CYC(BASE), .OPEN_CYC(OPEN)) i_gate_predrv_ctrl (
        .clk(clk), .rst_n(rst_n), .drv_en_n(drv_en_n), .gate_in(gate_in),
        .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_cmd(cfg_cmd),
        .cfg_filt(cfg_filt), .cfg_thr(cfg_thr), .maxi_in(maxi_in),
        .short_in(short_in), .open_in(open_in), .spark_fb(spark_fb),
        .gate_out(gate_out), .fault_short(fault_short), .fault_open(fault_open),
        .spark_n(spark_n), .thr_code(thr_code)
    );

    typedef enum int {SIG_GATE, SIG_FSHORT, SIG_FOPEN, SIG_SPARK, SIG_THR} sig_e;
    typedef struct {
        string      req;
        sig_e       sig;
        logic [3:0] exp;
    } item_t;

    item_t q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    task automatic push(input string req, input sig_e sig, input logic [3:0] exp);
        item_t it;
        it.req = req; it.sig = sig; it.exp = exp;
        q.push_back(it);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cfg(input logic [3:0] m, input logic [3:0] c,
                       input logic [2:0] f, input logic [2:0] t);
        cfg_mode = m; cfg_cmd = c; cfg_filt = f; cfg_thr = t;
        cfg_wr = 1'b1;
        cyc(1);
        cfg_wr = 1'b0;
    endtask

    // monitor: compares queued expectations mid-cycle
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [3:0] act;
            it = q.pop_front();
            case (it.sig)
                SIG_GATE:   act = gate_out;
                SIG_FSHORT: act = fault_short;
                SIG_FOPEN:  act = fault_open;
                SIG_SPARK:  act = {3'b000, spark_n};
                default:    act = {1'b0, thr_code};
            endcase
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s sig=%0d: got %b exp %b", it.req, it.sig, act, it.exp);
            end
        end
    end

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: got hung exp finished");
            summary();
            $finish;
        end
    end

    task automatic clear_ch0;
        gate_in = 4'b0100; cyc(1);
        gate_in = 4'b0101; cyc(1);
    endtask

    initial begin
        // R1 reset state
        cyc(2);
        push("R1", SIG_GATE, 4'b0000);
        push("R1", SIG_FSHORT, 4'b0000);
        push("R1", SIG_FOPEN, 4'b0000);
        push("R1", SIG_SPARK, 4'b0001);
        push("R1", SIG_THR, 4'b0000);
        rst_n = 1'b1;
        cyc(1);

        // R13 threshold code, R2 ignition ignores stored command
        cfg(4'b0000, 4'b1111, 3'd0, 3'd3);
        push("R13", SIG_THR, 4'b0011);
        cyc(1);
        push("R2", SIG_GATE, 4'b0000);
        gate_in = 4'b0101; cyc(1);
        push("R2", SIG_GATE, 4'b0101);

        // R3 general-purpose OR
        cfg(4'b1111, 4'b0010, 3'd0, 3'd5);
        push("R13", SIG_THR, 4'b0101);
        cyc(1);
        push("R3", SIG_GATE, 4'b0111);

        // R4 global disable
        drv_en_n = 1'b1; cyc(1);
        push("R4", SIG_GATE, 4'b0000);
        drv_en_n = 1'b0; cyc(1);
        push("R4", SIG_GATE, 4'b0111);

        // R5 max-current latch
        maxi_in = 4'b0001; cyc(1);
        push("R5", SIG_GATE, 4'b0110);
        maxi_in = 4'b0000; cyc(3);
        push("R5", SIG_GATE, 4'b0110);

        // R6 release clears the latch
        gate_in = 4'b0100; cyc(1);
        push("R6", SIG_GATE, 4'b0110);
        gate_in = 4'b0101; cyc(1);
        push("R6", SIG_GATE, 4'b0111);
        // R6 max-current in the same cycle as a low command
        gate_in = 4'b0100; maxi_in = 4'b0001; cyc(1);
        maxi_in = 4'b0000; gate_in = 4'b0101; cyc(1);
        push("R6", SIG_GATE, 4'b0111);

        // R7 short filter, code 0 -> 4 clocks
        short_in = 4'b0001; cyc(3);
        push("R7", SIG_FSHORT, 4'b0000);
        push("R7", SIG_GATE, 4'b0111);
        cyc(1);
        push("R7", SIG_FSHORT, 4'b0001);
        push("R7", SIG_GATE, 4'b0110);
        // R9 held after flag drops, cleared by release
        short_in = 4'b0000; cyc(2);
        push("R9", SIG_FSHORT, 4'b0001);
        push("R9", SIG_GATE, 4'b0110);
        gate_in = 4'b0100; cyc(1);
        push("R9", SIG_FSHORT, 4'b0000);
        gate_in = 4'b0101; cyc(1);
        push("R9", SIG_GATE, 4'b0111);

        // R7 restart on a one-clock gap
        short_in = 4'b0001; cyc(2);
        short_in = 4'b0000; cyc(1);
        short_in = 4'b0001; cyc(3);
        push("R7", SIG_FSHORT, 4'b0000);
        cyc(1);
        push("R7", SIG_FSHORT, 4'b0001);
        short_in = 4'b0000;
        clear_ch0();

        // R7 code 2 -> 16 clocks
        cfg(4'b1111, 4'b0010, 3'd2, 3'd5);
        short_in = 4'b0001; cyc(15);
        push("R7", SIG_FSHORT, 4'b0000);
        cyc(1);
        push("R7", SIG_FSHORT, 4'b0001);
        short_in = 4'b0000;
        clear_ch0();

        // R8 code 7 saturates at 128 clocks
        cfg(4'b1111, 4'b0010, 3'd7, 3'd5);
        short_in = 4'b0001; cyc(127);
        push("R8", SIG_FSHORT, 4'b0000);
        cyc(1);
        push("R8", SIG_FSHORT, 4'b0001);
        short_in = 4'b0000;
        clear_ch0();

        // R10 ignition channel ignores the short flag
        cfg(4'b1110, 4'b0010, 3'd0, 3'd5);
        short_in = 4'b0001; cyc(10);
        push("R10", SIG_FSHORT, 4'b0000);
        push("R10", SIG_GATE, 4'b0111);
        short_in = 4'b0000;

        // R11 open-load filter on channel 3 (off)
        open_in = 4'b1000; cyc(OPEN - 1);
        push("R11", SIG_FOPEN, 4'b0000);
        cyc(1);
        push("R11", SIG_FOPEN, 4'b1000);
        open_in = 4'b0000; cyc(2);
        push("R11", SIG_FOPEN, 4'b1000);
        gate_in = 4'b1101; cyc(1);
        push("R11", SIG_FOPEN, 4'b0000);
        push("R11", SIG_GATE, 4'b1111);

        // R12 spark indicator
        spark_fb = 4'b0100; cyc(1);
        push("R12", SIG_SPARK, 4'b0000);
        spark_fb = 4'b0000; cyc(1);
        push("R12", SIG_SPARK, 4'b0001);
        spark_fb = 4'b1001; cyc(1);
        push("R12", SIG_SPARK, 4'b0000);

        cyc(3);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule